// File: doc/BRIEF.md
# Phase-Steppable Reloadable Clock Divider

This block divides a fast reference clock (for example about 120 MHz) down to a slower output clock, typically somewhere between 1 and 20 MHz. A down-counter runs at the fast clock and reloads itself each time it reaches zero, so every pass from the reload value down to zero makes one output period. The division ratio is given directly in fast-clock cycles.

The output phase can be stepped forward in fixed increments. When a shift is requested, the counter uses a shorter reload value for exactly one period and then returns to the nominal ratio. That one period therefore ends early, and every later edge moves earlier by the step. The step size can be a quarter, an eighth or a sixteenth of the output period. A busy flag shows that a shift is waiting to be applied. Ratio and step changes only take effect at period boundaries, so the output never shows a broken period.

Top module: `phase_step_divider`

## Requirements
- R1: While reset is asserted, `clk_div_o` and `busy_o` are both 0.
- R2: On the first rising fast-clock edge after reset is released, the counter loads a new period and `clk_div_o` goes high.
- R3: With no shift pending, each output period lasts exactly `ratio_i` fast cycles, and the output is high for the first floor(ratio/2) of them. This also holds for odd ratios.
- R4: `step_sel_i` sets the step size S as follows: 0 gives ratio/4, 1 gives ratio/8, and both 2 and 3 give ratio/16 (integer division). The shortened period lasts ratio − S cycles.
- R5: Exactly one period is shortened per accepted request. The periods on either side of it last the full ratio.
- R6: A request (`shift_req_i` high for one cycle while `busy_o` is low) sets `busy_o` on the next edge. `busy_o` stays high until the edge that loads the shortened period and falls on that edge. The shortened period is the one that starts at the first period boundary after the request is registered.
- R7: A request that arrives while `busy_o` is high is ignored, so only one period is shortened.
- R8: The counter reads `ratio_i` and `step_sel_i` only at its zero count. A change made in the middle of a period leaves that period unchanged and applies from the next period on.
- R9: The shortened period of length P is high for its first floor(P/2) fast cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ratio_i | input | CNT_W | Nominal period length in fast cycles |
| step_sel_i | input | 2 | Step select: 0 = 1/4, 1 = 1/8, 2 or 3 = 1/16 of the period |
| shift_req_i | input | 1 | Single-cycle request to advance the phase by one step |
| clk_div_o | output | 1 | Divided output clock |
| busy_o | output | 1 | High while an accepted shift is waiting to be applied |

## Verification
The output rises on the same fast edge that reloads the counter, and a registered request shows on `busy_o` one edge after it is sampled. The shortened period is the second period that completes after the request, with `busy_o` falling at its opening edge. The bench samples outputs on falling edges and logs every completed output period as a length and a high count. Requests are always issued two edges into a period, so the period in progress cannot end on the same edge and it is known which logged period must be the short one. Mid-period changes to ratio and step are made just after a logged rise, so they must leave that period at its old length.

// File: rtl/psd_pkg.sv
package psd_pkg;

   // Encoding of the step-size selector.
   typedef enum logic [1:0] {
      STEP_QUARTER   = 2'd0,
      STEP_EIGHTH    = 2'd1,
      STEP_SIXTEENTH = 2'd2,
      STEP_SIXT_ALT  = 2'd3
   } step_sel_e;

   // Number of distinct step fractions (1/4, 1/8, 1/16).
   localparam int unsigned STEP_KINDS = 3;
   // Smallest fraction exponent: step = ratio >> (STEP_BASE_SHIFT + k).
   localparam int unsigned STEP_BASE_SHIFT = 2;
   // Shortest period the counter will accept.
   localparam int unsigned MIN_PERIOD = 2;

   // Map the selector onto an index into the candidate step table.
   function automatic int unsigned step_index(step_sel_e sel);
      case (sel)
         STEP_QUARTER: return 0;
         STEP_EIGHTH:  return 1;
         default:      return 2;
      endcase
   endfunction

endpackage

// File: rtl/psd_reload_sel.sv
module psd_reload_sel
   import psd_pkg::*;
#(
   parameter int unsigned CNT_W = 16
) (
   input  logic [CNT_W-1:0] ratio_i,
   input  logic [1:0]       step_sel_i,
   input  logic             apply_i,
   output logic [CNT_W-1:0] period_o
);

   localparam logic [CNT_W-1:0] MIN_P = CNT_W'(MIN_PERIOD);

   logic [CNT_W-1:0] cand [STEP_KINDS];
   logic [CNT_W-1:0] step;
   logic [CNT_W-1:0] raw;

   // One candidate step per supported fraction of the period.
   for (genvar k = 0; k < STEP_KINDS; k++) begin : g_cand
      assign cand[k] = ratio_i >> (STEP_BASE_SHIFT + k);
   end

   always_comb begin
      step = cand[step_index(step_sel_e'(step_sel_i))];
      raw  = apply_i ? (ratio_i - step) : ratio_i;
      // Guard against degenerate ratios so the counter always completes.
      period_o = (raw < MIN_P) ? MIN_P : raw;
   end

endmodule

// File: rtl/psd_down_counter.sv
module psd_down_counter #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [CNT_W-1:0] period_i,
   output logic             tc_o,
   output logic [CNT_W-1:0] cnt_next_o,
   output logic [CNT_W-1:0] thr_next_o
);

   logic [CNT_W-1:0] cnt_q, thr_q;
   logic [CNT_W-1:0] cnt_d, thr_d;

   assign tc_o = (cnt_q == '0);

   // At zero the counter takes the next period; the high/low split
   // point is ceil(P/2) counts from the bottom, giving floor(P/2) high.
   always_comb begin
      if (tc_o) begin
         cnt_d = period_i - 1'b1;
         thr_d = period_i - (period_i >> 1);
      end else begin
         cnt_d = cnt_q - 1'b1;
         thr_d = thr_q;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
         thr_q <= CNT_W'(1);
      end else begin
         cnt_q <= cnt_d;
         thr_q <= thr_d;
      end
   end

   assign cnt_next_o = cnt_d;
   assign thr_next_o = thr_d;

endmodule

// File: rtl/psd_duty_gen.sv
module psd_duty_gen #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [CNT_W-1:0] cnt_next_i,
   input  logic [CNT_W-1:0] thr_next_i,
   output logic             clk_o
);

   logic out_q;

   // Registered so the divided clock leaves a flop, free of glitches.
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) out_q <= 1'b0;
      else         out_q <= (cnt_next_i >= thr_next_i);
   end

   assign clk_o = out_q;

endmodule

// File: rtl/psd_req_ctrl.sv
module psd_req_ctrl (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic req_i,
   input  logic tc_i,
   output logic pend_o
);

   logic pend_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)              pend_q <= 1'b0;
      else if (pend_q && tc_i)  pend_q <= 1'b0;
      else if (req_i)           pend_q <= 1'b1;
   end

   assign pend_o = pend_q;

endmodule

// File: rtl/phase_step_divider.sv
module phase_step_divider #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [CNT_W-1:0] ratio_i,
   input  logic [1:0]       step_sel_i,
   input  logic             shift_req_i,
   output logic             clk_div_o,
   output logic             busy_o
);

   if (CNT_W < 5) begin : g_bad_width
      $error("phase_step_divider: CNT_W must be at least 5");
   end

   logic             tc;
   logic             pend;
   logic [CNT_W-1:0] period;
   logic [CNT_W-1:0] cnt_next;
   logic [CNT_W-1:0] thr_next;

   psd_req_ctrl u_req (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .req_i  (shift_req_i),
      .tc_i   (tc),
      .pend_o (pend)
   );

   psd_reload_sel #(.CNT_W(CNT_W)) u_sel (
      .ratio_i    (ratio_i),
      .step_sel_i (step_sel_i),
      .apply_i    (pend),
      .period_o   (period)
   );

   psd_down_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .period_i   (period),
      .tc_o       (tc),
      .cnt_next_o (cnt_next),
      .thr_next_o (thr_next)
   );

   psd_duty_gen #(.CNT_W(CNT_W)) u_duty (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .cnt_next_i (cnt_next),
      .thr_next_i (thr_next),
      .clk_o      (clk_div_o)
   );

   assign busy_o = pend;

endmodule

// File: rtl/psd_chk.sv
module psd_chk (
   input logic clk_i,
   input logic rst_ni,
   input logic shift_req_i,
   input logic clk_div_o,
   input logic busy_o,
   input logic tc_i
);

   // R6
   req_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      shift_req_i && !busy_o |=> busy_o);

   // R7
   busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy_o && !tc_i |=> busy_o);

   // R5
   busy_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy_o && tc_i |=> !busy_o);

   // R2
   rise_at_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(clk_div_o) |-> $past(tc_i));

   // R3
   fall_mid_period_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(clk_div_o) |-> !$past(tc_i));

endmodule

bind phase_step_divider psd_chk u_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .shift_req_i (shift_req_i),
   .clk_div_o   (clk_div_o),
   .busy_o      (busy_o),
   .tc_i        (tc)
);

// File: tb/phase_step_divider_tb.sv
module phase_step_divider_tb;

   localparam int W = 16;
   localparam int NV = 8;
   // {ratio, step_sel, expected shortened length}
   localparam logic [33:0] VECS [NV] = '{
      {16'd16, 2'd0, 16'd12},
      {16'd16, 2'd1, 16'd14},
      {16'd16, 2'd2, 16'd15},
      {16'd32, 2'd2, 16'd30},
      {16'd64, 2'd0, 16'd48},
      {16'd48, 2'd1, 16'd42},
      {16'd48, 2'd3, 16'd45},
      {16'd80, 2'd2, 16'd75}
   };

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [W-1:0] ratio = 16'd16;
   logic [1:0]   sel = 2'd0;
   logic         req = 1'b0;
   logic         dout, busy;

   int n_chk = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   phase_step_divider #(.CNT_W(W)) u_dut (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .ratio_i     (ratio),
      .step_sel_i  (sel),
      .shift_req_i (req),
      .clk_div_o   (dout),
      .busy_o      (busy)
   );

   // Period log, built from falling-edge samples of the output.
   int   plen [1024];
   int   phi  [1024];
   int   log_n = 0;
   int   cur_len = 0;
   int   cur_hi = 0;
   bit   started = 1'b0;
   logic prev = 1'b0;

   always @(negedge clk) begin
      if (!rst_n) begin
         prev = 1'b0;
         started = 1'b0;
      end else begin
         if (dout && !prev) begin
            if (started && log_n < 1024) begin
               plen[log_n] = cur_len;
               phi[log_n]  = cur_hi;
               log_n++;
            end
            started = 1'b1;
            cur_len = 1;
            cur_hi  = 1;
         end else begin
            cur_len++;
            if (dout) cur_hi++;
         end
         prev = dout;
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic wait_rise();
      int t = log_n;
      while (log_n == t) begin
         @(negedge clk);
         #1;
      end
   endtask

   task automatic pulse_req();
      @(posedge clk); #1 req = 1'b1;
      @(posedge clk); #1 req = 1'b0;
   endtask

   task automatic set_mode(input int r, input int s);
      @(posedge clk); #1;
      ratio = W'(r);
      sel   = 2'(s);
      wait_rise();
      wait_rise();
   endtask

   task automatic finish_up();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      #1_000_000;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_up();
   end

   initial begin
      int idx;
      // R1: reset state
      repeat (3) @(negedge clk);
      chk("R1 out in reset", int'(dout), 0);
      chk("R1 busy in reset", int'(busy), 0);

      // R2: first rise one edge after release
      @(posedge clk); #1 rst_n = 1'b1;
      @(negedge clk);
      chk("R2 out before first edge", int'(dout), 0);
      @(negedge clk); #1;
      chk("R2 out after first edge", int'(dout), 1);
      idx = log_n;
      wait_rise();
      chk("R3 first period length", plen[idx], 16);
      chk("R3 first period high", phi[idx], 8);

      // R3: odd ratio
      set_mode(21, 0);
      idx = log_n;
      wait_rise();
      chk("R3 odd length", plen[idx], 21);
      chk("R3 odd high", phi[idx], 10);

      // R4 R5 R6 R9: vector table
      for (int v = 0; v < NV; v++) begin
         int n, e;
         n = int'(VECS[v][33:18]);
         e = int'(VECS[v][15:0]);
         set_mode(n, int'(VECS[v][17:16]));
         idx = log_n;
         chk("R6 busy idle", int'(busy), 0);
         pulse_req();
         chk("R6 busy set", int'(busy), 1);
         wait_rise();
         chk("R6 busy cleared at load", int'(busy), 0);
         wait_rise();
         wait_rise();
         chk("R5 period before", plen[idx], n);
         chk("R4 shortened length", plen[idx+1], e);
         chk("R9 shortened high", phi[idx+1], e / 2);
         chk("R5 period after", plen[idx+2], n);
         chk("R3 period after high", phi[idx+2], n / 2);
      end

      // R7: second request while busy is ignored
      set_mode(32, 0);
      idx = log_n;
      pulse_req();
      pulse_req();
      chk("R7 busy still set", int'(busy), 1);
      wait_rise();
      wait_rise();
      wait_rise();
      wait_rise();
      chk("R7 shortened once", plen[idx+1], 24);
      chk("R7 no second shortening", plen[idx+2], 32);
      chk("R7 still nominal", plen[idx+3], 32);

      // R8: ratio change mid-period
      set_mode(32, 0);
      idx = log_n;
      @(posedge clk); #1 ratio = 16'd48;
      wait_rise();
      wait_rise();
      chk("R8 old ratio kept", plen[idx], 32);
      chk("R8 new ratio applied", plen[idx+1], 48);

      // R8: step select change before the shortened period loads
      set_mode(32, 0);
      idx = log_n;
      pulse_req();
      @(posedge clk); #1 sel = 2'd2;
      wait_rise();
      wait_rise();
      chk("R8 step sampled at boundary", plen[idx+1], 30);

      // R1: reset while a shift is pending
      set_mode(64, 0);
      pulse_req();
      @(posedge clk); #1 rst_n = 1'b0;
      @(negedge clk);
      chk("R1 busy cleared by reset", int'(busy), 0);
      chk("R1 out cleared by reset", int'(dout), 0);

      finish_up();
   end

endmodule